// File: doc/BRIEF.md
# Sixteen-bit load sequencer

This block runs the 16-bit load instructions of a small 8-bit processor core, one clock per T-state. It holds six 16-bit registers: the pairs BC, DE, HL, the stack pointer SP and the two index registers IX and IY. It fetches opcode bytes and operand bytes over a byte-wide memory port and carries out three kinds of work:
- loading a register from the two immediate bytes after the opcode;
- copying HL, IX or IY into SP;
- writing a register to a direct 16-bit address, low byte first.

Every machine cycle has a fixed length, so each instruction takes the same number of clocks every time it runs.

Two prefix families widen the decode. An index prefix makes the next opcode work on IX or IY instead of HL. An extension prefix selects the store form that can name any register pair. A byte the block does not recognise, with or without a prefix, raises a one-clock illegal-opcode pulse. The block then drops the instruction and fetches the next byte as a fresh opcode.

The memory port has no back-pressure and no handshake. Address and strobes are held for the whole of a machine cycle. The memory must present `mem_rdata` for the current address before the last T-state of a fetch or read cycle, where the block samples it. The port does not stall, and the memory cannot insert wait states.

Top module: `ld16_seq`

## Requirements
- R1: While reset is held, the block presents T1 of an opcode fetch at address 0: `cyc_type`=0, `t_state`=1, `mem_rd`=1, `mem_wr`=0, and `instr_done` and `illegal_opcode` are low.
- R2: `t_state` counts 1,2,... up to the length of the current machine cycle, one step per clock, and then restarts at 1. `mem_addr` stays constant within a machine cycle.
- R3: Opcode 00 rp 0001 loads a pair from the two following bytes, low byte first. The rp field codes are 00=BC, 01=DE, 10=HL, 11=SP. The machine cycles are fetch 4, read 3, read 3 (10 clocks).
- R4: Index prefix 11 N 11101 (N=0 gives IX, 0xDD; N=1 gives IY, 0xFD) followed by 0x21 loads the index register from immediate bytes. The machine cycles are fetch 4, fetch 4, read 3, read 3 (14 clocks).
- R5: Opcode 0xF9 copies HL into SP in a single fetch cycle of 6 T-states.
- R6: An index prefix followed by 0xF9 copies IX or IY into SP in two fetch cycles of 4 and 6 T-states.
- R7: Opcode 0x22 takes address bytes nn (low, then high) and writes HL low to nn and HL high to nn+1. The machine cycles are fetch 4, read 3, read 3, write 3, write 3 (16 clocks).
- R8: Extension prefix 0xED followed by 01 rp 0011 stores the pair coded by rp (R3 encoding) the same way. The machine cycles are fetch 4, fetch 4, read 3, read 3, write 3, write 3 (20 clocks).
- R9: An index prefix followed by 0x22 stores IX or IY the same way, with the same 20-clock schedule as R8.
- R10: The second write address nn+1 wraps modulo 2^16, so nn=0xFFFF writes the high byte to 0x0000.
- R11: `cyc_type` reports 0 during opcode fetch cycles, 1 during operand read cycles and 2 during write cycles. The value 3 is never produced.
- R12: `instr_done` is high for exactly the last T-state of every completed instruction, and the next clock is T1 of an opcode fetch.
- R13: An unrecognised byte raises `illegal_opcode` on T4 of its fetch. This covers an unprefixed byte, any byte after a prefix that is outside the group, and a second prefix. The next clock starts a fresh fetch at the following byte, and no register and no memory location changes.
- R14: `mem_rd` is high in T1–T4 of fetch cycles and throughout read cycles, and low in T5–T6 of a stretched fetch. `mem_wr` is high throughout write cycles and never together with `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address, held for a machine cycle |
| mem_rd | output | 1 | Read strobe (fetch and operand read) |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte returned for `mem_addr`, sampled on the cycle's last T-state |
| cyc_type | output | 2 | Machine cycle kind: 0 fetch, 1 read, 2 write |
| t_state | output | 3 | Current T-state number, starting at 1 |
| instr_done | output | 1 | Last T-state of a completed instruction |
| illegal_opcode | output | 1 | One-clock pulse on an unrecognised byte |

## Verification
The properties assume that `rst_n` is asserted at start-up and that `mem_rdata` is a plain function of `mem_addr` that settles within the clock. No wait states or stalls are expected. The bench models memory as a combinational array lookup, so the read data always arrives in time. Its programs are straight-line byte sequences that fit in that array, and the random stores pick any 16-bit target, including the top of the address space. Random opcodes are drawn only from the load group and from a fixed set of bytes known to lie outside it, so every instruction has a known expected schedule.

// File: rtl/ld16_pkg.sv
package ld16_pkg;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned SLOTS    = 2 ** SEL_W;

  typedef enum logic [1:0] {CY_FETCH = 2'd0, CY_READ = 2'd1, CY_WRITE = 2'd2} cyc_e;
  typedef enum logic [2:0] {PH_FETCH, PH_RDLO, PH_RDHI, PH_WRLO, PH_WRHI} phase_e;
  typedef enum logic [1:0] {PF_NONE, PF_IX, PF_IY, PF_EXT} pfx_e;
  typedef enum logic [2:0] {K_ILL, K_PFX, K_LDI, K_SPCP, K_STORE} kind_e;
  typedef enum logic [SEL_W-1:0] {RS_BC = 3'd0, RS_DE = 3'd1, RS_HL = 3'd2,
                                  RS_SP = 3'd3, RS_IX = 3'd4, RS_IY = 3'd5} rsel_e;
endpackage

// File: rtl/ld16_decode.sv
module ld16_decode
  import ld16_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  input  pfx_e             pfx,
  output kind_e            kind,
  output rsel_e            sel,
  output pfx_e             new_pfx
);
  rsel_e idx;
  assign idx = (pfx == PF_IY) ? RS_IY : RS_IX;

  always_comb begin
    kind    = K_ILL;
    sel     = RS_HL;
    new_pfx = PF_NONE;
    unique case (pfx)
      PF_NONE: begin
        if (op == 8'hDD) begin
          kind = K_PFX; new_pfx = PF_IX;
        end else if (op == 8'hFD) begin
          kind = K_PFX; new_pfx = PF_IY;
        end else if (op == 8'hED) begin
          kind = K_PFX; new_pfx = PF_EXT;
        end else if (op[7:6] == 2'b00 && op[3:0] == 4'b0001) begin
          kind = K_LDI; sel = rsel_e'({1'b0, op[5:4]});
        end else if (op == 8'hF9) begin
          kind = K_SPCP;
        end else if (op == 8'h22) begin
          kind = K_STORE;
        end
      end
      PF_IX, PF_IY: begin
        sel = idx;
        if (op == 8'h21)      kind = K_LDI;
        else if (op == 8'hF9) kind = K_SPCP;
        else if (op == 8'h22) kind = K_STORE;
      end
      PF_EXT: begin
        if (op[7:6] == 2'b01 && op[3:0] == 4'b0011) begin
          kind = K_STORE; sel = rsel_e'({1'b0, op[5:4]});
        end
      end
      default: kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/ld16_regfile.sv
module ld16_regfile
  import ld16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  rsel_e        wsel,
  input  logic [W-1:0] wdata,
  input  rsel_e        rsel,
  output logic [W-1:0] rdata
);
  logic [W-1:0] slot [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_REGS) begin : g_live
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q <= '0;
        else if (we && wsel == rsel_e'(SEL_W'(g))) q <= wdata;
      end
      assign slot[g] = q;
    end else begin : g_pad
      assign slot[g] = '0;
    end
  end

  assign rdata = slot[rsel];
endmodule

// File: rtl/ld16_seq.sv
module ld16_seq
  import ld16_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        cyc_type,
  output logic [2:0]        t_state,
  output logic              instr_done,
  output logic              illegal_opcode
);
  localparam int unsigned PAIR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [2:0] LEN_FETCH = 3'd4, LEN_MEM = 3'd3, LEN_LONG = 3'd6;

  phase_e            phase;
  pfx_e              pfx, dec_pfx;
  kind_e             kind_q, dec_kind, eff_kind;
  rsel_e             sel_q, dec_sel, wsel;
  logic [2:0]        t, mlen;
  logic [ADDR_W-1:0] pc, nn;
  logic [DATA_W-1:0] lo_q;
  logic [PAIR_W-1:0] rf_rdata, rf_wdata;
  logic              at_dec, stretch, last_t, rf_we;

  ld16_decode u_dec (
    .op(mem_rdata), .pfx(pfx), .kind(dec_kind), .sel(dec_sel), .new_pfx(dec_pfx)
  );

  assign at_dec   = (phase == PH_FETCH) && (t == LEN_FETCH);
  assign stretch  = at_dec && (mlen == LEN_FETCH) && (dec_kind == K_SPCP);
  assign last_t   = (t == mlen) && !stretch;
  assign eff_kind = at_dec ? dec_kind : kind_q;

  assign rf_we    = last_t && (((phase == PH_FETCH) && (eff_kind == K_SPCP)) ||
                               ((phase == PH_RDHI) && (kind_q == K_LDI)));
  assign wsel     = (phase == PH_FETCH) ? RS_SP : sel_q;
  assign rf_wdata = (phase == PH_FETCH) ? rf_rdata : {mem_rdata, lo_q};

  ld16_regfile #(.W(PAIR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wsel(wsel), .wdata(rf_wdata),
    .rsel(sel_q), .rdata(rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      pfx    <= PF_NONE;
      kind_q <= K_ILL;
      sel_q  <= RS_HL;
      t      <= 3'd1;
      mlen   <= LEN_FETCH;
      pc     <= ADDR_W'(RESET_PC);
      nn     <= '0;
      lo_q   <= '0;
    end else begin
      if (at_dec) begin
        kind_q <= dec_kind;
        sel_q  <= dec_sel;
      end
      if (stretch) mlen <= LEN_LONG;
      if (!last_t) begin
        t <= t + 3'd1;
      end else begin
        t <= 3'd1;
        unique case (phase)
          PH_FETCH: begin
            pc <= pc + ONE_A;
            if (eff_kind == K_PFX) begin
              pfx  <= dec_pfx;
              mlen <= LEN_FETCH;
            end else if (eff_kind == K_LDI || eff_kind == K_STORE) begin
              phase <= PH_RDLO;
              mlen  <= LEN_MEM;
            end else begin
              pfx  <= PF_NONE;
              mlen <= LEN_FETCH;
            end
          end
          PH_RDLO: begin
            pc    <= pc + ONE_A;
            lo_q  <= mem_rdata;
            phase <= PH_RDHI;
          end
          PH_RDHI: begin
            pc <= pc + ONE_A;
            if (kind_q == K_STORE) begin
              nn    <= ADDR_W'({mem_rdata, lo_q});
              phase <= PH_WRLO;
            end else begin
              phase <= PH_FETCH;
              mlen  <= LEN_FETCH;
              pfx   <= PF_NONE;
            end
          end
          PH_WRLO: phase <= PH_WRHI;
          PH_WRHI: begin
            phase <= PH_FETCH;
            mlen  <= LEN_FETCH;
            pfx   <= PF_NONE;
          end
          default: phase <= PH_FETCH;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_WRLO: mem_addr = nn;
      PH_WRHI: mem_addr = nn + ONE_A;
      default: mem_addr = pc;
    endcase
  end

  assign mem_rd    = ((phase == PH_FETCH) && (t <= LEN_FETCH)) ||
                     (phase == PH_RDLO) || (phase == PH_RDHI);
  assign mem_wr    = (phase == PH_WRLO) || (phase == PH_WRHI);
  assign mem_wdata = (phase == PH_WRHI) ? rf_rdata[PAIR_W-1:DATA_W] : rf_rdata[DATA_W-1:0];
  assign cyc_type  = (phase == PH_FETCH) ? CY_FETCH :
                     (mem_wr ? CY_WRITE : CY_READ);
  assign t_state   = t;
  assign instr_done = last_t && (((phase == PH_FETCH) && (eff_kind == K_SPCP)) ||
                                 ((phase == PH_RDHI) && (kind_q == K_LDI)) ||
                                 (phase == PH_WRHI));
  assign illegal_opcode = at_dec && (dec_kind == K_ILL);
endmodule

// File: rtl/ld16_seq_chk.sv
module ld16_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [1:0]        cyc_type,
  input logic [2:0]        t_state,
  input logic              instr_done,
  input logic              illegal_opcode
);
  assert_tstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state != 3'd1) |-> (t_state == $past(t_state) + 3'd1));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state != 3'd1) |-> $stable(mem_addr));

  assert_no_type3_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type != 2'd3);

  assert_rw_excl_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_done_refetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (cyc_type == 2'd0 && t_state == 3'd1));

  assert_ill_refetch_R13: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_opcode |=> (cyc_type == 2'd0 && t_state == 3'd1));

  assert_ill_at_t4_R13: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_opcode |-> (cyc_type == 2'd0 && t_state == 3'd4 && !instr_done));

  assert_wr_next_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'd2 && t_state == 3'd1 && $past(cyc_type) == 2'd2)
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

bind ld16_seq ld16_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ld16_seq_bench.sv
module ld16_seq_bench;
  localparam int MEMN = 1024, SIGW = 100, MAXI = 256, MAXW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, instr_done, illegal_opcode;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  cyc_type;
  logic [2:0]  t_state;
  logic [7:0]  mem [MEMN];
  assign mem_rdata = mem[mem_addr[9:0]];

  ld16_seq u_ld16_seq (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cyc_type(cyc_type), .t_state(t_state),
    .instr_done(instr_done), .illegal_opcode(illegal_opcode)
  );

  int errs = 0, checks = 0, pcb = 0, ni = 0, nw = 0, cur_clk = 0;
  logic [15:0]     rm [6];
  logic [SIGW-1:0] cur_sig, e_sig [MAXI];
  int              e_clk [MAXI];
  bit              e_ill [MAXI];
  string           e_req [MAXI], w_req [MAXI];
  logic [15:0]     w_addr [MAXW];
  logic [7:0]      w_data [MAXW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [SIGW-1:0] act, input logic [SIGW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b); mem[pcb] = b; pcb++; endtask
  task automatic addm(input logic [1:0] ty, input int len);
    for (int t = 1; t <= len; t++) begin cur_sig = {cur_sig[SIGW-6:0], ty, 3'(t)}; cur_clk++; end
  endtask
  task automatic close(input bit ill, input string req);
    e_sig[ni] = cur_sig; e_clk[ni] = cur_clk; e_ill[ni] = ill; e_req[ni] = req; ni++;
    cur_sig = '0; cur_clk = 0;
  endtask
  task automatic expw(input logic [15:0] a, input logic [7:0] d, input string req);
    w_addr[nw] = a; w_data[nw] = d; w_req[nw] = req; nw++;
  endtask
  function automatic logic [7:0] ipfx(input int x); return x ? 8'hFD : 8'hDD; endfunction

  // R3: immediate pair load
  task automatic i_ldi(input int r, input logic [15:0] v);
    emit({2'b00, 2'(r), 4'b0001}); emit(v[7:0]); emit(v[15:8]);
    addm(0, 4); addm(1, 3); addm(1, 3); rm[r] = v; close(0, "R3");
  endtask
  // R4: index immediate load
  task automatic i_ldx(input int x, input logic [15:0] v);
    emit(ipfx(x)); emit(8'h21); emit(v[7:0]); emit(v[15:8]);
    addm(0, 4); addm(0, 4); addm(1, 3); addm(1, 3); rm[4+x] = v; close(0, "R4");
  endtask
  // R5
  task automatic i_sphl();
    emit(8'hF9); addm(0, 6); rm[3] = rm[2]; close(0, "R5");
  endtask
  // R6
  task automatic i_spx(input int x);
    emit(ipfx(x)); emit(8'hF9); addm(0, 4); addm(0, 6); rm[3] = rm[4+x]; close(0, "R6");
  endtask
  task automatic store_tail(input logic [15:0] a, input logic [15:0] v, input string req);
    emit(a[7:0]); emit(a[15:8]);
    addm(1, 3); addm(1, 3); addm(2, 3); addm(2, 3);
    expw(a, v[7:0], req); expw(a + 16'd1, v[15:8], (a == 16'hFFFF) ? "R10" : req);
    close(0, req);
  endtask
  // R7
  task automatic i_sthl(input logic [15:0] a);
    emit(8'h22); addm(0, 4); store_tail(a, rm[2], "R7");
  endtask
  // R8
  task automatic i_sted(input int r, input logic [15:0] a);
    emit(8'hED); emit({2'b01, 2'(r), 4'b0011}); addm(0, 4); addm(0, 4);
    store_tail(a, rm[r], "R8");
  endtask
  // R9
  task automatic i_stx(input int x, input logic [15:0] a);
    emit(ipfx(x)); emit(8'h22); addm(0, 4); addm(0, 4); store_tail(a, rm[4+x], "R9");
  endtask
  // R13
  task automatic i_ill1(input logic [7:0] b);
    emit(b); addm(0, 4); close(1, "R13");
  endtask
  task automatic i_ill2(input logic [7:0] p, input logic [7:0] b);
    emit(p); emit(b); addm(0, 4); addm(0, 4); close(1, "R13");
  endtask

  function automatic logic [7:0] pick4(input logic [31:0] l, input int i);
    return l[8*i +: 8];
  endfunction

  initial begin
    int ib, wb, cc, tot;
    bit wd;
    logic [SIGW-1:0] cs;
    void'($urandom(32'h5EED_1D16));
    for (int i = 0; i < MEMN; i++) mem[i] = 8'h00;
    for (int i = 0; i < 6; i++) rm[i] = '0;
    cur_sig = '0;

    // directed corner cases
    i_ldi(2, 16'h1234);
    i_sphl();
    i_sted(3, 16'h0400);
    i_ldx(0, 16'hA55A);
    i_spx(0);
    i_sted(3, 16'h0402);
    i_ldx(1, 16'h0FF0);
    i_stx(1, 16'hFFFF);
    i_sthl(16'hFFFF);
    i_ill1(8'h76);
    i_ill2(8'hDD, 8'h00);
    i_ill2(8'hED, 8'h22);
    i_ill2(8'hFD, 8'hFD);
    i_sted(2, 16'h8000);
    // constrained random
    for (int k = 0; k < 90; k++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] v = 16'($urandom);
      case (sel)
        0, 1: i_ldi($urandom_range(0, 3), v);
        2: i_ldx($urandom_range(0, 1), v);
        3: i_sphl();
        4: i_spx($urandom_range(0, 1));
        5: i_sthl(v);
        6: i_sted($urandom_range(0, 3), v);
        7: i_stx($urandom_range(0, 1), v);
        8: i_ill1(pick4(32'hC33E7600, $urandom_range(0, 3)));
        default: begin
          int p = $urandom_range(0, 2);
          if (p == 2) i_ill2(8'hED, pick4(32'h21224B00, $urandom_range(0, 3)));
          else        i_ill2(ipfx(p), pick4(32'h01ED2300, $urandom_range(0, 3)));
        end
      endcase
    end
    // final readout of every register
    for (int r = 0; r < 4; r++) i_sted(r, 16'h0500 + 16'(2*r));
    i_stx(0, 16'h0600);
    i_stx(1, 16'h0602);

    repeat (3) @(negedge clk);
    chk({mem_addr, cyc_type, t_state, mem_rd, mem_wr, instr_done, illegal_opcode} ==
        {16'h0000, 2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0}, "R1", "reset state",
        {mem_addr, cyc_type, t_state, mem_rd, mem_wr, instr_done, illegal_opcode},
        {16'h0000, 2'd0, 3'd1, 4'b1000});
    @(posedge clk); #1 rst_n = 1'b1;

    ib = 0; wb = 0; cc = 0; tot = 0; wd = 1'b0; cs = '0;
    while (ib < ni && !wd) begin
      @(negedge clk);
      tot++; cc++;
      cs = {cs[SIGW-6:0], cyc_type, t_state};
      if (cyc_type == 2'd2 && t_state == 3'd1)
        chk(mem_wr && !mem_rd, "R14", "write strobes", {mem_rd, mem_wr}, 2'b01);
      if (cyc_type == 2'd0 && t_state == 3'd5)
        chk(!mem_rd && !mem_wr, "R14", "stretched fetch strobes", {mem_rd, mem_wr}, 2'b00);
      if (mem_wr && t_state == 3'd3) begin
        if (wb < nw)
          chk({mem_addr, mem_wdata} == {w_addr[wb], w_data[wb]}, w_req[wb], "write addr/data",
              {mem_addr, mem_wdata}, {w_addr[wb], w_data[wb]});
        else
          chk(1'b0, "R13", "unexpected write", {mem_addr, mem_wdata}, '0);
        wb++;
      end
      if (instr_done || illegal_opcode) begin
        chk(cs == e_sig[ib] && cc == e_clk[ib], e_req[ib], "cycle/T-state schedule (R2 R11)",
            cs, e_sig[ib]);
        chk({instr_done, illegal_opcode} == {!e_ill[ib], e_ill[ib]},
            e_ill[ib] ? "R13" : "R12", "end pulse kind",
            {instr_done, illegal_opcode}, {!e_ill[ib], e_ill[ib]});
        ib++; cc = 0; cs = '0;
      end
      if (cc > 40 || tot > 150000) wd = 1'b1;
    end
    if (wd) chk(1'b0, "R12", "watchdog expired", SIGW'(ib), SIGW'(ni));
    chk(wb == nw, "R7", "write count", SIGW'(wb), SIGW'(nw));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule